// File: doc/BRIEF.md
# Standard-Definition Sync Pulse Generator

This block produces the horizontal and vertical sync pulses of a standard-definition raster. Two counters do the work: a sample counter advanced by the pixel clock, and a line counter. Both are exposed. The widths and edge offsets of the pulses are chosen from small encoded option sets by two-bit configuration fields. A further field slides the pixel-valid window by up to three clocks relative to horizontal sync.

Software restarts the raster by taking a control bit high and then low again. A mode input selects between two counting modes. In locked mode the line counter wraps at the end of the frame on its own. In free-running mode it keeps counting past the frame end and is brought back to zero only by a falling edge on an external vertical sync. All outputs are registered. Sync outputs are active low. An odd-field flag marks the first half of the frame.

Top module: `sd_sync_gen`

## Requirements
- R1: `hsync_n` goes low at sample 0 of every line and stays low for 1, 4, 16 or 128 clocks when `hs_width_sel` is 00, 01, 10 or 11.
- R2: On line 0, `vsync_n` falls 0, 4, 8 or 18 clocks after the `hsync_n` falling edge when `vs_delay_sel` is 00, 01, 10 or 11 and `vs_half_line` is 0.
- R3: With `vs_half_line` at 1, the `vsync_n` falling edge moves a further LINE_SAMPLES/2 clocks later than the R2 offset.
- R4: `vsync_n` stays low for 6 half-lines (3 lines) by default. It stays low for 5 half-lines (2.5 lines) when VS_SHORT is set, which is the default for a 625-line frame.
- R5: `pix_valid` rises ACTIVE_START + `pix_adjust` clocks after the `hsync_n` falling edge and stays high for ACTIVE_LEN clocks.
- R6: A high-then-low sequence on `timing_reset_bit` zeroes `line_cnt` and `samp_cnt` in the clock after the bit is sampled low. Holding the bit high alone leaves the counters running.
- R7: With `free_run` at 0, `line_cnt` goes from FRAME_LINES-1 to 0 at the end of the last line. In this mode `ext_vsync_n` has no effect.
- R8: With `free_run` at 1, `line_cnt` counts past FRAME_LINES-1. A falling edge on `ext_vsync_n` zeroes both counters in the clock after it is sampled.
- R9: `odd_field` is 1 while the line count is below ceil(FRAME_LINES/2) and 0 otherwise.
- R10: During reset, `hsync_n` and `vsync_n` are 1, `pix_valid` is 0, `odd_field` is 1, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_width_sel | input | 2 | Horizontal sync width code |
| vs_delay_sel | input | 2 | Horizontal-to-vertical sync delay code |
| vs_half_line | input | 1 | Add half a line to the vertical sync offset |
| pix_adjust | input | 2 | Pixel-valid shift, 0 to 3 clocks |
| timing_reset_bit | input | 1 | Control bit; a high-low sequence restarts the counters |
| free_run | input | 1 | 0: wrap at frame end; 1: wrap on external vertical sync |
| ext_vsync_n | input | 1 | External vertical sync, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| odd_field | output | 1 | First-field flag |
| line_cnt | output | $clog2(FRAME_LINES) | Current line |
| samp_cnt | output | $clog2(LINE_SAMPLES) | Current sample within the line |
| pix_valid | output | 1 | Active pixel strobe |

## Verification
The bench builds the block with 320 samples per line, 11 lines per frame, an active window starting at sample 40 and lasting 200 samples. A second instance sets VS_SHORT. These values give a 3520-clock frame, so frame wrap and counting past the frame end in free-running mode both happen within a few thousand cycles. The half-line length of 160 still leaves room for the widest horizontal sync and the largest half-line vertical offset inside one line. Every width, delay and adjust code is measured from edge to edge on the outputs, and both vertical sync lengths are measured side by side.

// File: rtl/sd_sync_gen.sv
module sd_sync_gen #(
  parameter int LINE_SAMPLES = 1716,
  parameter int FRAME_LINES  = 525,
  parameter int ACTIVE_START = 244,
  parameter int ACTIVE_LEN   = 1440,
  parameter bit VS_SHORT     = (FRAME_LINES == 625)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      hs_width_sel,
  input  logic [1:0]                      vs_delay_sel,
  input  logic                            vs_half_line,
  input  logic [1:0]                      pix_adjust,
  input  logic                            timing_reset_bit,
  input  logic                            free_run,
  input  logic                            ext_vsync_n,
  output logic                            hsync_n,
  output logic                            vsync_n,
  output logic                            odd_field,
  output logic [$clog2(FRAME_LINES)-1:0]  line_cnt,
  output logic [$clog2(LINE_SAMPLES)-1:0] samp_cnt,
  output logic                            pix_valid
);
  localparam int SW     = $clog2(LINE_SAMPLES);
  localparam int LW     = $clog2(FRAME_LINES);
  localparam int HALF   = LINE_SAMPLES / 2;
  localparam int VS_LEN = (VS_SHORT ? 5 : 6) * HALF;
  localparam int VW     = $clog2(VS_LEN + 1);
  localparam int FIELD1 = (FRAME_LINES + 1) / 2;

  logic          tr_q, ext_q;
  logic [VW-1:0] vs_rem;
  logic [SW-1:0] hs_len, vs_base, vs_off, pv_start, pv_end;

  always_comb begin
    case (hs_width_sel)
      2'd0:    hs_len = SW'(1);
      2'd1:    hs_len = SW'(4);
      2'd2:    hs_len = SW'(16);
      default: hs_len = SW'(128);
    endcase
    case (vs_delay_sel)
      2'd0:    vs_base = SW'(0);
      2'd1:    vs_base = SW'(4);
      2'd2:    vs_base = SW'(8);
      default: vs_base = SW'(18);
    endcase
  end

  assign vs_off   = vs_base + (vs_half_line ? SW'(HALF) : '0);
  assign pv_start = SW'(ACTIVE_START) + SW'(pix_adjust);
  assign pv_end   = pv_start + SW'(ACTIVE_LEN);

  wire tr_fire   = tr_q & ~timing_reset_bit;
  wire ext_fire  = free_run & ext_q & ~ext_vsync_n;
  wire restart   = tr_fire | ext_fire;
  wire samp_last = (samp_cnt == SW'(LINE_SAMPLES - 1));
  wire line_last = !free_run && (line_cnt >= LW'(FRAME_LINES - 1));
  wire vs_hit    = !restart && (line_cnt == '0) && (samp_cnt == vs_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_q      <= 1'b0;
      ext_q     <= 1'b1;
      samp_cnt  <= '0;
      line_cnt  <= '0;
      vs_rem    <= '0;
      hsync_n   <= 1'b1;
      vsync_n   <= 1'b1;
      pix_valid <= 1'b0;
      odd_field <= 1'b1;
    end else begin
      tr_q  <= timing_reset_bit;
      ext_q <= ext_vsync_n;

      if (restart) begin
        samp_cnt <= '0;
        line_cnt <= '0;
      end else if (samp_last) begin
        samp_cnt <= '0;
        line_cnt <= line_last ? '0 : line_cnt + LW'(1);
      end else begin
        samp_cnt <= samp_cnt + SW'(1);
      end

      if (restart)            vs_rem <= '0;
      else if (vs_hit)        vs_rem <= VW'(VS_LEN - 1);
      else if (vs_rem != '0)  vs_rem <= vs_rem - VW'(1);

      hsync_n   <= !(samp_cnt < hs_len);
      vsync_n   <= !(vs_hit || (vs_rem != '0));
      pix_valid <= (samp_cnt >= pv_start) && (samp_cnt < pv_end);
      odd_field <= (line_cnt < LW'(FIELD1));
    end
  end
endmodule

module sd_sync_gen_chk #(
  parameter int LINE_SAMPLES = 1716,
  parameter int FRAME_LINES  = 525,
  parameter int ACTIVE_START = 244
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            timing_reset_bit,
  input logic                            free_run,
  input logic                            hsync_n,
  input logic                            vsync_n,
  input logic                            pix_valid,
  input logic [$clog2(FRAME_LINES)-1:0]  line_cnt,
  input logic [$clog2(LINE_SAMPLES)-1:0] samp_cnt
);
  assert_restart_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(timing_reset_bit) && !timing_reset_bit) |=> (samp_cnt == '0 && line_cnt == '0));

  assert_samp_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(samp_cnt) < LINE_SAMPLES);

  assert_locked_line_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_cnt == '0 && int'($past(samp_cnt)) == LINE_SAMPLES - 1 && !$past(free_run))
      |-> int'(line_cnt) < FRAME_LINES);

  assert_hsync_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> int'($past(samp_cnt)) < 128);

  assert_pixel_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> (int'($past(samp_cnt)) >= ACTIVE_START &&
                          int'($past(samp_cnt)) <= ACTIVE_START + 3));

  assert_vsync_on_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(line_cnt) == '0);
endmodule

bind sd_sync_gen sd_sync_gen_chk #(
  .LINE_SAMPLES(LINE_SAMPLES), .FRAME_LINES(FRAME_LINES), .ACTIVE_START(ACTIVE_START)
) u_chk (
  .clk(clk), .rst_n(rst_n), .timing_reset_bit(timing_reset_bit), .free_run(free_run),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .pix_valid(pix_valid),
  .line_cnt(line_cnt), .samp_cnt(samp_cnt)
);

// File: tb/tb_sd_sync_gen.sv
module tb_sd_sync_gen;
  localparam int LS = 320;
  localparam int FL = 11;
  localparam int AS = 40;
  localparam int AL = 200;
  localparam int SW = $clog2(LS);
  localparam int LW = $clog2(FL);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] hs_width_sel = 0, vs_delay_sel = 0, pix_adjust = 0;
  logic vs_half_line = 0, timing_reset_bit = 0, free_run = 0, ext_vsync_n = 1;
  logic hsync_n, vsync_n, odd_field, pix_valid;
  logic hs_s, vs_s, odd_s, pv_s;
  logic [LW-1:0] line_cnt, line_s;
  logic [SW-1:0] samp_cnt, samp_s;

  always #2 clk = ~clk;

  sd_sync_gen #(.LINE_SAMPLES(LS), .FRAME_LINES(FL), .ACTIVE_START(AS), .ACTIVE_LEN(AL),
                .VS_SHORT(1'b0)) dut (
    .clk, .rst_n, .hs_width_sel, .vs_delay_sel, .vs_half_line, .pix_adjust,
    .timing_reset_bit, .free_run, .ext_vsync_n, .hsync_n, .vsync_n, .odd_field,
    .line_cnt, .samp_cnt, .pix_valid);

  sd_sync_gen #(.LINE_SAMPLES(LS), .FRAME_LINES(FL), .ACTIVE_START(AS), .ACTIVE_LEN(AL),
                .VS_SHORT(1'b1)) dut_short (
    .clk, .rst_n, .hs_width_sel, .vs_delay_sel, .vs_half_line, .pix_adjust,
    .timing_reset_bit, .free_run, .ext_vsync_n, .hsync_n(hs_s), .vsync_n(vs_s),
    .odd_field(odd_s), .line_cnt(line_s), .samp_cnt(samp_s), .pix_valid(pv_s));

  typedef struct { string tag; int val; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic expect_v(string tag, int v);
    q.push_back('{tag, v});
  endtask

  task automatic got(int actual);
    exp_t e;
    e = q.pop_front();
    checks++;
    if (actual != e.val) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", e.tag, actual, e.val);
    end
  endtask

  task automatic wait_at(int l, int s);
    while (!(int'(line_cnt) == l && int'(samp_cnt) == s)) @(negedge clk);
  endtask

  task automatic measure(int hs, int vd, bit half, int adj);
    int hw[4] = '{1, 4, 16, 128};
    int dl[4] = '{0, 4, 8, 18};
    int t_h = -1, w_h = -1, t_v = -1, w_v = -1, w_vs = -1, t_vs = -1, t_p = -1, w_p = -1;
    logic ph, pv, pp, pvs;
    hs_width_sel = 2'(hs); vs_delay_sel = 2'(vd); vs_half_line = half; pix_adjust = 2'(adj);
    expect_v("R6 line after restart", 0);
    expect_v("R6 samp after restart", 0);
    expect_v("R1 hsync width", hw[hs]);
    expect_v(half ? "R3 vsync offset" : "R2 vsync offset", dl[vd] + (half ? LS / 2 : 0));
    expect_v("R4 vsync width", 6 * LS / 2);
    expect_v("R4 short vsync width", 5 * LS / 2);
    expect_v("R5 pixel offset", AS + adj);
    expect_v("R5 pixel width", AL);
    wait_at(5, 250);
    timing_reset_bit = 1;
    @(negedge clk) timing_reset_bit = 0;
    @(negedge clk);
    got(int'(line_cnt));
    got(int'(samp_cnt));
    ph = hsync_n; pv = vsync_n; pp = pix_valid; pvs = vs_s;
    for (int t = 1; t <= 1400; t++) begin
      @(negedge clk);
      if (ph && !hsync_n && t_h < 0) t_h = t;
      if (!ph && hsync_n && t_h >= 0 && w_h < 0) w_h = t - t_h;
      if (pv && !vsync_n && t_v < 0) t_v = t;
      if (!pv && vsync_n && t_v >= 0 && w_v < 0) w_v = t - t_v;
      if (pvs && !vs_s && t_vs < 0) t_vs = t;
      if (!pvs && vs_s && t_vs >= 0 && w_vs < 0) w_vs = t - t_vs;
      if (!pp && pix_valid && t_p < 0) t_p = t;
      if (pp && !pix_valid && t_p >= 0 && w_p < 0) w_p = t - t_p;
      ph = hsync_n; pv = vsync_n; pp = pix_valid; pvs = vs_s;
    end
    got(w_h);
    got(t_v - t_h);
    got(w_v);
    got(w_vs);
    got(t_p - t_h);
    got(w_p);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_v("R10 hsync_n", 1); got(int'(hsync_n));
    expect_v("R10 vsync_n", 1); got(int'(vsync_n));
    expect_v("R10 pix_valid", 0); got(int'(pix_valid));
    expect_v("R10 odd_field", 1); got(int'(odd_field));
    expect_v("R10 counters", 0); got(int'(line_cnt) + int'(samp_cnt));
    rst_n = 1;

    measure(0, 0, 0, 0);
    measure(1, 1, 0, 1);
    measure(2, 2, 0, 2);
    measure(3, 3, 0, 3);
    measure(3, 3, 1, 0);
    measure(0, 1, 1, 3);

    // R6: bit held high alone does not restart
    wait_at(3, 200);
    timing_reset_bit = 1;
    repeat (3) @(negedge clk);
    expect_v("R6 held high keeps counting", 203); got(int'(samp_cnt));
    timing_reset_bit = 0;
    @(negedge clk);
    expect_v("R6 fall restarts", 0); got(int'(samp_cnt) + int'(line_cnt));

    // R9
    wait_at(5, 5);
    expect_v("R9 odd_field line 5", 1); got(int'(odd_field));
    wait_at(6, 5);
    expect_v("R9 odd_field line 6", 0); got(int'(odd_field));

    // R7: locked wrap, external sync ignored
    wait_at(FL - 1, LS - 1);
    @(negedge clk);
    expect_v("R7 wrap line", 0); got(int'(line_cnt));
    expect_v("R7 wrap samp", 0); got(int'(samp_cnt));
    wait_at(2, 100);
    ext_vsync_n = 0;
    @(negedge clk) ext_vsync_n = 1;
    @(negedge clk);
    expect_v("R7 ext ignored samp", 102); got(int'(samp_cnt));
    expect_v("R7 ext ignored line", 2); got(int'(line_cnt));

    // R8: free running
    free_run = 1;
    wait_at(FL - 1, LS - 1);
    @(negedge clk);
    expect_v("R8 counts past frame", FL); got(int'(line_cnt));
    wait_at(FL + 1, 50);
    ext_vsync_n = 0;
    @(negedge clk);
    expect_v("R8 ext line", 0); got(int'(line_cnt));
    expect_v("R8 ext samp", 0); got(int'(samp_cnt));
    ext_vsync_n = 1;
    free_run = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule